// File: doc/BRIEF.md
# Polyphase DPSK Transmit Modulator

This block converts a serial bit stream into oversampled in-phase and quadrature baseband samples. It supports two differential phase modes. In the four-phase mode, pairs of bits set the step in carrier phase and every step is an odd multiple of pi/4. In the eight-phase mode, triplets of bits set the step and any multiple of pi/4 is allowed. Both modes run at one symbol every eight output samples. The running carrier phase is held as a 3-bit index in units of pi/4.

Pulse shaping uses a polyphase network that spans four symbol periods. Each of the eight output phases has its own small coefficient ROM of four taps. During a symbol period, a sample counter walks through the branches. The active branch's taps weight the unit-circle components of the last four symbol phases. The same hardware serves both modes.

The upstream source offers bits with a valid/ready handshake. A start strobe opens a new burst and latches the mode. The block lowers ready while it is emitting the eight samples of a completed symbol.

Top module: `dpsk_polyphase_mod`

## Requirements
- R1: After reset, `samp_valid` is 0, `bit_ready` is 1, and `i_out` and `q_out` are 0.
- R2: In four-phase mode (`mode_sel`=0), bits arrive first-bit-as-MSB. The code sets the phase step in units of pi/4: 00 gives +1, 01 gives +3, 11 gives +5 (that is, -3), and 10 gives +7 (that is, -1).
- R3: In eight-phase mode (`mode_sel`=1), the 3-bit code is Gray decoded, first bit as MSB, into a step in units of pi/4. The mapping is 000→0, 001→1, 011→2, 010→3, 110→4, 111→5, 101→6, 100→7.
- R4: The phase index resets to 0 on `start`. Each completed symbol adds its step modulo 8, and the first symbol after `start` therefore has a phase equal to its own step.
- R5: After the clock edge that accepts a symbol's last bit, exactly 8 consecutive cycles carry `samp_valid`=1. `bit_ready` is 0 for the first seven of these cycles and is 1 again in the eighth.
- R6: For sample k (0..7) of the current symbol, the I output is the sum over m=0..3 of h(k+8m)·C(p_m), arithmetically shifted right by 6. Here h(j)=64-((j-16)²·64/256), C(p) is {64,45,0,-45,-64,-45,0,45} for p=0..7, p_0 is the newest symbol's phase and p_3 the oldest. A slot not yet filled since `start` contributes 0. The Q output uses S(p)=C((p-2) mod 8) in place of C.
- R7: The I and Q results saturate to the range [-128, 127].
- R8: `start` clears the symbol history and any partly collected bits. It aborts an emission in progress, so `samp_valid` is 0 and `bit_ready` is 1 in the following cycle. A bit offered in the same cycle as `start` is not taken.
- R9: The mode is latched only on `start`. A change of `mode_sel` between strobes has no effect on the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Burst start strobe; latches mode and clears state |
| mode_sel | input | 1 | 0 = four-phase, 1 = eight-phase |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` is offered |
| bit_ready | output | 1 | Block can take a bit this cycle |
| i_out | output | 8 | Signed in-phase sample |
| q_out | output | 8 | Signed quadrature sample |
| samp_valid | output | 1 | `i_out`/`q_out` hold a new sample |

## Verification
Two functions can fall in the same cycle here. The first is a `start` strobe that lands while a symbol's samples are still streaming out; it must abort the stream and wipe the filter history in one edge. The second is a `start` that coincides with an offered bit, which must not be taken. The bench provokes both from negedge-driven tasks: it strobes `start` after three samples of a symbol, and it raises `start` together with `bit_valid`. It judges the result by the ports in the next cycle and by the exact sample values of the following symbol. A leftover history slot or a stray bit would shift every one of those values.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
  localparam int TAP_W  = 8;
  localparam int UNIT_W = 8;

  // four-phase step in units of pi/4
  function automatic logic [2:0] step_four(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd3;
      2'b11:   return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  // eight-phase step: Gray code to binary
  function automatic logic [2:0] step_eight(input logic [2:0] code);
    logic [2:0] b;
    b[2] = code[2];
    b[1] = b[2] ^ code[1];
    b[0] = b[1] ^ code[0];
    return b;
  endfunction

  // shaping tap j of a window of 'total' taps, peak 64 at the centre
  function automatic int tap_value(input int j, input int total);
    int c, d;
    c = total / 2;
    d = j - c;
    return 64 - (d * d * 64) / (c * c);
  endfunction

  // cosine of p*pi/4 scaled by 64
  function automatic logic signed [UNIT_W-1:0] cos_unit(input logic [2:0] p);
    case (p)
      3'd0:    return 8'sd64;
      3'd1:    return 8'sd45;
      3'd2:    return 8'sd0;
      3'd3:    return -8'sd45;
      3'd4:    return -8'sd64;
      3'd5:    return -8'sd45;
      3'd6:    return 8'sd0;
      default: return 8'sd45;
    endcase
  endfunction

  function automatic logic signed [UNIT_W-1:0] sin_unit(input logic [2:0] p);
    return cos_unit(p - 3'd2);
  endfunction
endpackage

// File: rtl/dpsk_symbol_mapper.sv
module dpsk_symbol_mapper
  import dpsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode_sel,
  input  logic       bit_in,
  input  logic       bit_valid,
  input  logic       stall,
  output logic       bit_ready,
  output logic       push,
  output logic [2:0] push_phase
);
  logic [1:0] cnt;
  logic [1:0] held;
  logic [2:0] phase;
  logic       mode_q;
  logic       take;
  logic       last_bit;
  logic [2:0] step;

  assign bit_ready  = !stall;
  assign take       = bit_valid && bit_ready && !start;
  assign last_bit   = (cnt == (mode_q ? 2'd2 : 2'd1));
  assign push       = take && last_bit;
  assign step       = mode_q ? step_eight({held, bit_in}) : step_four({held[0], bit_in});
  assign push_phase = phase + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      held   <= '0;
      phase  <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      held   <= '0;
      phase  <= '0;
      mode_q <= mode_sel;
    end else if (take) begin
      held <= {held[0], bit_in};
      if (last_bit) begin
        cnt   <= '0;
        phase <= push_phase;
      end else begin
        cnt <= cnt + 2'd1;
      end
    end
  end

  // R4: phase moves only on a completed symbol or a start
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !start) |=> $stable(phase));
  // R4: start returns the phase to zero
  a_r4_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == 3'd0));
  // R2: every four-phase step is odd, so the phase parity flips
  a_r2_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !mode_q) |=> (phase[0] != $past(phase[0])));
  // R9: latched mode changes only on start
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mode_q));
endmodule

// File: rtl/dpsk_poly_filter.sv
module dpsk_poly_filter
  import dpsk_pkg::*;
#(
  parameter int SPS   = 8,
  parameter int SPAN  = 4,
  parameter int OUT_W = 8,
  parameter int SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    push,
  input  logic [2:0]              push_phase,
  output logic                    busy,
  output logic                    o_valid,
  output logic signed [OUT_W-1:0] o_i,
  output logic signed [OUT_W-1:0] o_q
);
  localparam int KW    = $clog2(SPS);
  localparam int TOTAL = SPS * SPAN;
  localparam int MAXV  = 2 ** (OUT_W - 1) - 1;
  localparam int MINV  = -(2 ** (OUT_W - 1));

  logic [2:0]              hist_p [SPAN];
  logic [SPAN-1:0]         hist_v;
  logic [KW-1:0]           k;
  logic signed [TAP_W-1:0] rom [SPS][SPAN];
  logic signed [31:0]      acc_i, acc_q;
  logic signed [OUT_W-1:0] samp_i, samp_q;
  logic                    sample_tick;
  logic                    branch_last;

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [31:0] v);
    if (v > MAXV) return OUT_W'(MAXV);
    if (v < MINV) return OUT_W'(MINV);
    return v[OUT_W-1:0];
  endfunction

  // one coefficient ROM per output phase
  for (genvar b = 0; b < SPS; b++) begin : g_branch
    for (genvar m = 0; m < SPAN; m++) begin : g_tap
      localparam int TV = tap_value(b + SPS * m, TOTAL);
      assign rom[b][m] = TAP_W'(TV);
    end
  end

  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int m = 0; m < SPAN; m++) begin
      if (hist_v[m]) begin
        acc_i = acc_i + 32'(rom[k][m]) * 32'(cos_unit(hist_p[m]));
        acc_q = acc_q + 32'(rom[k][m]) * 32'(sin_unit(hist_p[m]));
      end
    end
    samp_i = clip(acc_i >>> SHIFT);
    samp_q = clip(acc_q >>> SHIFT);
  end

  assign sample_tick = busy && !clear;
  assign branch_last = (k == KW'(SPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < SPAN; m++) hist_p[m] <= '0;
      hist_v  <= '0;
      k       <= '0;
      busy    <= 1'b0;
      o_valid <= 1'b0;
      o_i     <= '0;
      o_q     <= '0;
    end else if (clear) begin
      for (int m = 0; m < SPAN; m++) hist_p[m] <= '0;
      hist_v  <= '0;
      k       <= '0;
      busy    <= 1'b0;
      o_valid <= 1'b0;
      o_i     <= '0;
      o_q     <= '0;
    end else if (push) begin
      for (int m = SPAN - 1; m > 0; m--) hist_p[m] <= hist_p[m-1];
      hist_p[0] <= push_phase;
      hist_v    <= {hist_v[SPAN-2:0], 1'b1};
      k         <= '0;
      busy      <= 1'b1;
      o_valid   <= 1'b0;
    end else if (sample_tick) begin
      o_i     <= samp_i;
      o_q     <= samp_q;
      o_valid <= 1'b1;
      k       <= k + 1'b1;
      if (branch_last) busy <= 1'b0;
    end else begin
      o_valid <= 1'b0;
    end
  end

  // R5: a new symbol is only loaded when idle
  a_r5_push_idle: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !busy);
  // R5: every busy cycle yields a sample
  a_r5_busy_emits: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> o_valid);
  // R8: clear silences the output and frees the input
  a_r8_clear_abort: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!o_valid && !busy));
  // R5: emission stops after the final branch
  a_r5_last_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && branch_last) |=> !busy);
endmodule

// File: rtl/dpsk_polyphase_mod.sv
module dpsk_polyphase_mod
  import dpsk_pkg::*;
#(
  parameter int SPS   = 8,
  parameter int SPAN  = 4,
  parameter int OUT_W = 8,
  parameter int SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode_sel,
  input  logic                    bit_in,
  input  logic                    bit_valid,
  output logic                    bit_ready,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out,
  output logic                    samp_valid
);
  logic       busy;
  logic       push;
  logic [2:0] push_phase;

  dpsk_symbol_mapper u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_sel   (mode_sel),
    .bit_in     (bit_in),
    .bit_valid  (bit_valid),
    .stall      (busy),
    .bit_ready  (bit_ready),
    .push       (push),
    .push_phase (push_phase)
  );

  dpsk_poly_filter #(
    .SPS   (SPS),
    .SPAN  (SPAN),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .push       (push),
    .push_phase (push_phase),
    .busy       (busy),
    .o_valid    (samp_valid),
    .o_i        (i_out),
    .o_q        (q_out)
  );

  // R8: a bit offered alongside start is refused
  a_r8_start_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !push);
endmodule

// File: tb/dpsk_polyphase_mod_tb.sv
module dpsk_polyphase_mod_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_sel = 1'b0, bit_in = 1'b0, bit_valid = 1'b0;
  logic bit_ready, samp_valid;
  logic signed [7:0] i_out, q_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ph;
  int hp [4];
  bit hv [4];
  bit saw_max = 0, saw_min = 0;

  localparam logic [15:0] VEC [7] = '{
    16'b0_000_001_011_010_000,
    16'b0_011_011_011_011_011,
    16'b1_000_000_000_000_000,
    16'b1_110_000_000_000_000,
    16'b1_001_011_010_111_101,
    16'b1_100_110_001_010_011,
    16'b0_010_010_001_000_001
  };
  localparam int FOUR_STEP  [4] = '{1, 3, 7, 5};
  localparam int EIGHT_STEP [8] = '{0, 1, 3, 2, 7, 6, 4, 5};

  dpsk_polyphase_mod u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .bit_in(bit_in), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .i_out(i_out), .q_out(q_out), .samp_valid(samp_valid)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int cosv(input int p);
    int t [8] = '{64, 45, 0, -45, -64, -45, 0, 45};
    return t[p & 7];
  endfunction

  function automatic int sinv(input int p);
    int t [8] = '{0, 45, 64, 45, 0, -45, -64, -45};
    return t[p & 7];
  endfunction

  function automatic int hcoef(input int j);
    return 64 - ((j - 16) * (j - 16)) / 4;
  endfunction

  function automatic int limit(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic model_reset();
    ph = 0;
    for (int m = 0; m < 4; m++) begin hp[m] = 0; hv[m] = 0; end
  endtask

  task automatic do_start(input bit md);
    @(negedge clk); start = 1'b1; mode_sel = md;
    @(negedge clk); start = 1'b0;
    model_reset();
  endtask

  task automatic send_bit(input bit b);
    bit_in = b; bit_valid = 1'b1;
    while (!bit_ready) @(negedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  // md: mode the model assumes; nsamp: samples to check
  task automatic send_symbol(input bit md, input logic [2:0] code, input int nsamp);
    int nb, si, sq, ei, eq;
    nb = md ? 3 : 2;
    for (int b = nb - 1; b >= 0; b--) send_bit(code[b]);
    ph = (ph + (md ? EIGHT_STEP[code] : FOUR_STEP[code[1:0]])) % 8;
    for (int m = 3; m > 0; m--) begin hp[m] = hp[m-1]; hv[m] = hv[m-1]; end
    hp[0] = ph; hv[0] = 1;
    for (int k = 0; k < nsamp; k++) begin
      si = 0; sq = 0;
      for (int m = 0; m < 4; m++)
        if (hv[m]) begin
          si += hcoef(k + 8 * m) * cosv(hp[m]);
          sq += hcoef(k + 8 * m) * sinv(hp[m]);
        end
      ei = limit(si >>> 6);
      eq = limit(sq >>> 6);
      @(negedge clk);
      if (int'(i_out) == 127) saw_max = 1;
      if (int'(i_out) == -128) saw_min = 1;
      chk(samp_valid && int'(i_out) == ei && int'(q_out) == eq && bit_ready == (k == 7),
          $sformatf("%s R4 R5 R6 sample %0d: actual v=%0d i=%0d q=%0d rdy=%0d expected v=1 i=%0d q=%0d rdy=%0d",
                    md ? "R3" : "R2", k, samp_valid, i_out, q_out, bit_ready, ei, eq, (k == 7)));
    end
  endtask

  initial begin
    // R1: reset state
    #35;
    chk(!samp_valid && bit_ready && i_out == 0 && q_out == 0,
        $sformatf("R1 in reset: actual v=%0d rdy=%0d i=%0d q=%0d expected 0 1 0 0",
                  samp_valid, bit_ready, i_out, q_out));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!samp_valid && bit_ready,
        $sformatf("R1 after reset: actual v=%0d rdy=%0d expected 0 1", samp_valid, bit_ready));

    // table of vectors
    foreach (VEC[v]) begin
      do_start(VEC[v][15]);
      for (int s = 0; s < 5; s++)
        send_symbol(VEC[v][15], VEC[v][14 - 3 * s -: 3], 8);
      @(negedge clk);
      chk(!samp_valid, $sformatf("R5 vector %0d idle after 8 samples: actual v=%0d expected 0", v, samp_valid));
    end

    // R7: both saturation limits seen
    chk(saw_max, "R7 positive limit: actual never 127 expected 127");
    chk(saw_min, "R7 negative limit: actual never -128 expected -128");

    // R9: mode input changed after start has no effect
    do_start(1'b0);
    mode_sel = 1'b1;
    send_symbol(1'b0, 3'b001, 8);
    send_symbol(1'b0, 3'b011, 8);
    send_symbol(1'b0, 3'b000, 8);

    // R8: start aborts an emission in progress
    do_start(1'b1);
    send_symbol(1'b1, 3'b110, 8);
    send_symbol(1'b1, 3'b001, 3);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    model_reset();
    chk(!samp_valid && bit_ready,
        $sformatf("R8 abort: actual v=%0d rdy=%0d expected 0 1", samp_valid, bit_ready));
    send_symbol(1'b1, 3'b011, 8);

    // R8: bit offered with start is not taken
    @(negedge clk);
    start = 1'b1; mode_sel = 1'b0; bit_in = 1'b1; bit_valid = 1'b1;
    @(negedge clk);
    start = 1'b0; bit_valid = 1'b0;
    model_reset();
    send_symbol(1'b0, 3'b000, 8);
    send_symbol(1'b0, 3'b010, 8);

    summary();
    $finish;
  end
endmodule